// File: doc/BRIEF.md
# Hardware Semaphore Bank

This block holds a small array of semaphores that several requesters share. Each requester raises a request for one semaphore, choosing either a take (P) or a release (V). A take finishes only when the chosen semaphore holds a value above zero. The value then drops by one in the same step as the grant, so no other requester can slip in between the test and the change. A release raises the value by one. Each requester holds its request until it sees its grant.

Each entry has a kind, fixed by a parameter:
- **Binary** entries only ever hold 0 or 1.
- **Counting** entries count free resources, up to the largest value the counter can hold.
- **Split** entries form one group in which at most one member is non-zero at any time.

A release that would break the rule for its kind still gets its grant. The value is left unchanged and a sticky error flag is raised. When requests arrive together, a round-robin arbiter serves one per cycle. A take that cannot proceed is passed over, so it never stalls a release from another requester.

Top module: `semBank`

## Requirements
- R1: After reset the grants are all low, the error flag is low, and each entry holds its configured initial value. Default configuration: entries 0, 1 and 7 are binary; entries 2 and 3 are counting; entries 4, 5 and 6 form the split group. The initial values are 1 for every entry except 5 and 6, which start at 0. Entry i is read from `semCount[i*CNT_W +: CNT_W]`.
- R2: A take (`reqOp` bit = 0) on an entry whose value is above zero raises that requester's grant for one cycle. The value is one lower after the next clock edge.
- R3: A take on an entry holding 0 gets no grant and leaves the value unchanged. It stays pending and is granted once the value becomes positive.
- R4: A release (`reqOp` bit = 1) on a counting entry below its maximum raises the value by one after the clock edge, and it is granted in the same cycle.
- R5: At most one grant is high in any cycle. Among eligible requesters, service starts at the requester after the one last served, wrapping around. After reset the search starts at requester 0.
- R6: A pending take that cannot proceed does not stop a release from another requester from being granted in the same cycle.
- R7: A release on a binary entry that holds 1 is granted, leaves the value at 1, and sets the error flag.
- R8: In the split group, at most one member is non-zero at any time. A release on a member while any member is non-zero is granted, changes no value and sets the error flag. A release while the whole group is 0 sets that member to 1.
- R9: A release on a counting entry at its maximum value (2^CNT_W - 1) is granted, leaves the value unchanged and sets the error flag.
- R10: Once set, the error flag stays high until reset, whatever operations follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Request present, one bit per requester, held until granted |
| reqOp | input | NUM_REQ | Operation per requester: 0 = take (P), 1 = release (V) |
| reqIdx | input | NUM_REQ*IDX_W | Target entry per requester, requester r at bits r*IDX_W +: IDX_W |
| grant | output | NUM_REQ | One-cycle completion pulse per requester |
| semCount | output | NUM_SEM*CNT_W | Current value of every entry |
| errFlag | output | 1 | Sticky flag for a rejected release |

## Verification
The assertions assume that a requester keeps `reqValid`, `reqOp` and `reqIdx` steady from the cycle it raises a request until the cycle its grant is seen. They also assume it drops the request right after the grant. They further assume that `reqIdx` always names an existing entry and that the configured initial values already respect the limits of each kind. The stimulus changes inputs only on the falling clock edge. It clears each request in the half cycle after its grant and only ever uses entry numbers 0 to 7, so it stays within these assumptions.

// File: rtl/semBankPkg.sv
package semBankPkg;

  typedef enum logic [1:0] {
    KIND_BIN   = 2'd0,
    KIND_CNT   = 2'd1,
    KIND_SPLIT = 2'd2
  } semKind_e;

  typedef struct packed {
    logic doP;
    logic doV;
  } semStrobe_t;

endpackage

// File: rtl/semBankCtrl.sv
module semBankCtrl
  import semBankPkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = 3,
  localparam int RW     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_REQ-1:0]       reqValid,
  input  logic [NUM_REQ-1:0]       reqOp,
  input  logic [NUM_REQ*IDX_W-1:0] reqIdx,
  input  logic [NUM_SEM-1:0]       semPos,
  output logic [NUM_REQ-1:0]       grant,
  output semStrobe_t               strobe,
  output logic [IDX_W-1:0]         opIdx
);

  logic [NUM_REQ-1:0] elig;
  logic [RW-1:0]      rrPtr;
  logic [RW-1:0]      pick;
  logic               found;

  // A requester is eligible for a release, or for a take when its entry is positive
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_elig
    assign elig[i] = reqValid[i] && (reqOp[i] || semPos[reqIdx[i*IDX_W +: IDX_W]]);
  end

  always_comb begin
    grant  = '0;
    strobe = '0;
    opIdx  = '0;
    pick   = '0;
    found  = 1'b0;
    for (int k = 0; k < NUM_REQ; k++) begin
      int j;
      j = int'(rrPtr) + k;
      if (j >= NUM_REQ) j = j - NUM_REQ;
      if (!found && elig[j]) begin
        found      = 1'b1;
        pick       = RW'(j);
        grant[j]   = 1'b1;
        opIdx      = reqIdx[j*IDX_W +: IDX_W];
        strobe.doP = !reqOp[j];
        strobe.doV = reqOp[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (found) begin
      rrPtr <= (int'(pick) == NUM_REQ - 1) ? '0 : pick + RW'(1);
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.doP && strobe.doV)); // R5

endmodule

// File: rtl/semBankData.sv
module semBankData
  import semBankPkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int CNT_W   = 4,
  parameter int IDX_W   = 3,
  parameter logic [2*NUM_SEM-1:0]     SEM_KINDS = 16'h2A50,
  parameter logic [NUM_SEM*CNT_W-1:0] INIT_VALS = 32'h1001_1111
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  semStrobe_t               strobe,
  input  logic [IDX_W-1:0]         opIdx,
  output logic [NUM_SEM-1:0]       semPos,
  output logic [NUM_SEM*CNT_W-1:0] semCount,
  output logic                     errFlag
);

  logic [CNT_W-1:0]   cnt [NUM_SEM];
  logic [NUM_SEM-1:0] splitNz;
  logic               splitAny;
  logic [CNT_W-1:0]   cur;
  semKind_e           kindSel;
  logic               vReject;

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_view
    localparam semKind_e K = semKind_e'(SEM_KINDS[2*i +: 2]);
    assign semPos[i]                   = (cnt[i] != '0);
    assign semCount[i*CNT_W +: CNT_W]  = cnt[i];
    assign splitNz[i]                  = (K == KIND_SPLIT) && (cnt[i] != '0);

    if (K != KIND_CNT) begin : g_one
      AST_BIN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
        cnt[i] <= CNT_W'(1)); // R7
    end

    AST_P_DEC: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.doP && opIdx == IDX_W'(i)) |=> cnt[i] == $past(cnt[i]) - CNT_W'(1)); // R2
  end

  assign splitAny = |splitNz;
  assign cur      = cnt[opIdx];
  assign kindSel  = semKind_e'(SEM_KINDS[2*opIdx +: 2]);

  always_comb begin
    unique case (kindSel)
      KIND_BIN:   vReject = (cur != '0);
      KIND_SPLIT: vReject = splitAny;
      KIND_CNT:   vReject = (cur == '1);
      default:    vReject = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEM; i++) cnt[i] <= INIT_VALS[i*CNT_W +: CNT_W];
      errFlag <= 1'b0;
    end else if (strobe.doP) begin
      cnt[opIdx] <= cur - CNT_W'(1);
    end else if (strobe.doV) begin
      if (vReject) errFlag    <= 1'b1;
      else         cnt[opIdx] <= cur + CNT_W'(1);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doP |-> cur != '0); // R3

  AST_SPLIT_SUM: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(splitNz)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R10

endmodule

// File: rtl/semBank.sv
module semBank
  import semBankPkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int NUM_SEM = 8,
  parameter int CNT_W   = 4,
  parameter logic [2*NUM_SEM-1:0]     SEM_KINDS = 16'h2A50,
  parameter logic [NUM_SEM*CNT_W-1:0] INIT_VALS = 32'h1001_1111,
  localparam int IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_REQ-1:0]       reqValid,
  input  logic [NUM_REQ-1:0]       reqOp,
  input  logic [NUM_REQ*IDX_W-1:0] reqIdx,
  output logic [NUM_REQ-1:0]       grant,
  output logic [NUM_SEM*CNT_W-1:0] semCount,
  output logic                     errFlag
);

  semStrobe_t         strobe;
  logic [IDX_W-1:0]   opIdx;
  logic [NUM_SEM-1:0] semPos;

  semBankCtrl #(
    .NUM_REQ(NUM_REQ), .NUM_SEM(NUM_SEM), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqIdx(reqIdx), .semPos(semPos), .grant(grant),
    .strobe(strobe), .opIdx(opIdx)
  );

  semBankData #(
    .NUM_SEM(NUM_SEM), .CNT_W(CNT_W), .IDX_W(IDX_W),
    .SEM_KINDS(SEM_KINDS), .INIT_VALS(INIT_VALS)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opIdx(opIdx),
    .semPos(semPos), .semCount(semCount), .errFlag(errFlag)
  );

endmodule

// File: tb/semBank_bench.sv
module semBank_bench;

  localparam int NR = 4;
  localparam int NS = 8;
  localparam int CW = 4;
  localparam int IW = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NR-1:0]   reqValid = '0;
  logic [NR-1:0]   reqOp = '0;
  logic [NR*IW-1:0] reqIdx = '0;
  logic [NR-1:0]   grant;
  logic [NS*CW-1:0] semCount;
  logic            errFlag;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  semBank u_semBank (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqIdx(reqIdx), .grant(grant), .semCount(semCount), .errFlag(errFlag)
  );

  function automatic int valOf(int idx);
    return int'(semCount[idx*CW +: CW]);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    reqValid = '0;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Present one request, wait up to maxWait cycles for its grant, then drop it
  task automatic doOp(int r, bit op, int idx, int maxWait, output bit got);
    @(negedge clk);
    reqValid[r] = 1'b1;
    reqOp[r] = op;
    reqIdx[r*IW +: IW] = IW'(idx);
    got = 1'b0;
    for (int w = 0; w < maxWait && !got; w++) begin
      #1;
      if (grant[r]) got = 1'b1;
      else @(negedge clk);
    end
    if (got) begin
      @(posedge clk);
      @(negedge clk);
    end
    reqValid[r] = 1'b0;
    #1;
  endtask

  task automatic tReset();
    doReset();
    #1;
    chk("R1", "grant", int'(grant), 0);
    chk("R1", "errFlag", int'(errFlag), 0);
    for (int i = 0; i < NS; i++)
      chk("R1", $sformatf("entry %0d", i), valOf(i), (i == 5 || i == 6) ? 0 : 1);
  endtask

  task automatic tTakeBasic();
    bit got;
    doReset();
    doOp(0, 1'b0, 2, 3, got);
    chk("R2", "take granted", int'(got), 1);
    chk("R2", "entry 2 after take", valOf(2), 0);
  endtask

  task automatic tBlockedThenRelease();
    doReset();
    @(negedge clk);
    reqValid[0] = 1'b1; reqOp[0] = 1'b0; reqIdx[0 +: IW] = 3'd2;
    @(posedge clk); @(negedge clk);
    reqValid[0] = 1'b0;
    #1;
    chk("R2", "entry 2 emptied", valOf(2), 0);
    @(negedge clk);
    reqValid[1] = 1'b1; reqOp[1] = 1'b0; reqIdx[IW +: IW] = 3'd2;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R3", "no grant on empty take", int'(grant), 0);
      @(negedge clk);
    end
    chk("R3", "entry 2 unchanged while blocked", valOf(2), 0);
    reqValid[2] = 1'b1; reqOp[2] = 1'b1; reqIdx[2*IW +: IW] = 3'd2;
    #1;
    chk("R6", "release passes blocked take", int'(grant), 4);
    @(posedge clk); @(negedge clk);
    reqValid[2] = 1'b0;
    #1;
    chk("R4", "entry 2 raised by release", valOf(2), 1);
    chk("R3", "pending take now granted", int'(grant), 2);
    @(posedge clk); @(negedge clk);
    reqValid[1] = 1'b0;
    #1;
    chk("R3", "entry 2 after late take", valOf(2), 0);
    chk("R3", "errFlag clear", int'(errFlag), 0);
  endtask

  task automatic tRoundRobin();
    doReset();
    @(negedge clk);
    for (int r = 0; r < NR; r++) begin
      reqValid[r] = 1'b1; reqOp[r] = 1'b0; reqIdx[r*IW +: IW] = IW'(r);
    end
    for (int k = 0; k < NR; k++) begin
      #1;
      chk("R5", $sformatf("serve order step %0d", k), int'(grant), 1 << k);
      @(posedge clk); @(negedge clk);
      reqValid[k] = 1'b0;
    end
    #1;
    for (int i = 0; i < NR; i++) chk("R5", $sformatf("entry %0d taken", i), valOf(i), 0);
    doReset();
    @(negedge clk);
    reqValid[1] = 1'b1; reqOp[1] = 1'b0; reqIdx[IW +: IW] = 3'd0;
    #1;
    chk("R5", "lone requester 1", int'(grant), 2);
    @(posedge clk); @(negedge clk);
    reqValid[1] = 1'b0;
    reqValid[0] = 1'b1; reqOp[0] = 1'b0; reqIdx[0 +: IW] = 3'd1;
    reqValid[3] = 1'b1; reqOp[3] = 1'b0; reqIdx[3*IW +: IW] = 3'd2;
    #1;
    chk("R5", "pointer past 1 favours 3", int'(grant), 8);
    @(posedge clk); @(negedge clk);
    reqValid[3] = 1'b0;
    #1;
    chk("R5", "then requester 0", int'(grant), 1);
    @(posedge clk); @(negedge clk);
    reqValid[0] = 1'b0;
  endtask

  task automatic tCounting();
    bit got;
    doReset();
    for (int v = 2; v <= 15; v++) begin
      doOp(2, 1'b1, 3, 3, got);
      chk("R4", "release granted", int'(got), 1);
      chk("R4", "entry 3 count", valOf(3), v);
    end
    chk("R9", "errFlag before max", int'(errFlag), 0);
    doOp(1, 1'b1, 3, 3, got);
    chk("R9", "release at max granted", int'(got), 1);
    chk("R9", "entry 3 saturated", valOf(3), 15);
    chk("R9", "errFlag at max", int'(errFlag), 1);
  endtask

  task automatic tBinary();
    bit got;
    doReset();
    doOp(0, 1'b1, 0, 3, got);
    chk("R7", "release on full binary granted", int'(got), 1);
    chk("R7", "entry 0 stays 1", valOf(0), 1);
    chk("R7", "errFlag set", int'(errFlag), 1);
    doOp(3, 1'b0, 0, 3, got);
    chk("R10", "entry 0 taken", valOf(0), 0);
    chk("R10", "errFlag still set", int'(errFlag), 1);
    doOp(3, 1'b1, 0, 3, got);
    chk("R10", "entry 0 restored", valOf(0), 1);
    chk("R10", "errFlag still set", int'(errFlag), 1);
  endtask

  task automatic tSplit();
    bit got;
    doReset();
    doOp(1, 1'b1, 5, 3, got);
    chk("R8", "rejected release granted", int'(got), 1);
    chk("R8", "entry 5 unchanged", valOf(5), 0);
    chk("R8", "entry 4 unchanged", valOf(4), 1);
    chk("R8", "errFlag set", int'(errFlag), 1);
    doReset();
    doOp(2, 1'b0, 4, 3, got);
    chk("R8", "entry 4 taken", valOf(4), 0);
    doOp(0, 1'b1, 6, 3, got);
    chk("R8", "entry 6 set", valOf(6), 1);
    chk("R8", "entry 5 idle", valOf(5), 0);
    chk("R8", "errFlag clear", int'(errFlag), 0);
  endtask

  initial begin
    tReset();
    tTakeBasic();
    tBlockedThenRelease();
    tRoundRobin();
    tCounting();
    tBinary();
    tSplit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule